// File: doc/BRIEF.md
# ECC Error Address Logger

This block sits beside the read and write datapath of a memory controller and records ECC events beat by beat. Each beat of a burst arrives with the burst base address, its position in the burst and two flags from the decoder: a corrected single-bit error and an uncorrectable double-bit error. The block works out the byte address of that beat and keeps it in one of two capture registers, one for each error class. It also counts single-bit errors in a saturating counter.

The single-bit interrupt has two modes. In the first it fires on every corrected error. In the second it fires only when the running count reaches a compare value that software has programmed. A double-bit error always raises its own interrupt at once. An external parity fault input is kept apart from ECC. It has its own sticky status bit and its own interrupt line, and it never touches the double-bit address log.

Software uses a small register port to set the mode and the compare value, to read the captured addresses, the count and the status, and to clear the status.

Top module: `ecc_addr_logger`

## Requirements
- R1: On a beat with `beat_valid` high, the logged address is `beat_base_addr + beat_idx * BEAT_BYTES` (BEAT_BYTES defaults to 8), for even and odd beat indices alike.
- R2: Single-bit and double-bit errors have separate capture registers. The first error of a class loads its register and sets that class's valid bit. A later error of the same class leaves the address unchanged and sets the overflow bit.
- R3: With the mode bit at 0, every single-bit error sets `irq_sbe`.
- R4: With the mode bit at 1, a single-bit error sets `irq_sbe` only when the count after the increment equals the compare value. With the compare value at 1, the first error both fires the interrupt and captures its own beat address.
- R5: `ext_parity_err` never changes the double-bit address or its valid bit. One cycle after it is asserted, STATUS bit 4 and `irq_par` are both high.
- R6: A double-bit error sets `irq_dbe` whatever the mode bit is. A beat that carries both flags is logged only as a double-bit error, and the single-bit count does not change.
- R7: The single-bit counter stops at 2^CNT_W-1 (255 by default) and never wraps.
- R8: Register map, selected by `reg_addr`:
  - 0: CTRL, bit 0 is the mode.
  - 1: CMP, bits [CNT_W-1:0] hold the compare value.
  - 2: STATUS, with bit 0 single-bit valid, bit 1 double-bit valid, bit 2 single-bit overflow, bit 3 double-bit overflow, bit 4 parity, bit 5 single-bit interrupt pending.
  - 3: single-bit address.
  - 4: double-bit address.
  - 5: count.

  STATUS is write-one-to-clear, as follows:
  - Bit 0 clears the single-bit valid and overflow bits.
  - Bit 1 clears the double-bit valid and overflow bits and `irq_dbe`.
  - Bit 4 clears the parity bit and `irq_par`.
  - Bit 5 clears the count and `irq_sbe`.

  After reset every register and interrupt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_valid | input | 1 | A beat is present this cycle |
| beat_base_addr | input | ADDR_W | Start address of the burst |
| beat_idx | input | IDX_W | Position of the beat within the burst |
| beat_sbe | input | 1 | Corrected single-bit error on this beat |
| beat_dbe | input | 1 | Uncorrectable double-bit error on this beat |
| ext_parity_err | input | 1 | External parity fault |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register that `reg_addr` selects |
| irq_sbe | output | 1 | Single-bit error interrupt |
| irq_dbe | output | 1 | Double-bit error interrupt |
| irq_par | output | 1 | Parity fault interrupt |

## Verification
The assertions check the following properties on every cycle:
- The beat address is captured at the first single-bit error.
- The double-bit address holds while no double-bit beat arrives.
- A double-bit error raises its interrupt at once.
- A beat with both flags leaves the count alone.
- In mode 0 every corrected error fires the interrupt.
- The counter stays at its maximum once it gets there.
- The parity fault raises its own interrupt.

Three behaviours can only be shown by the bench's scenarios:
- The compare-match mode, both with a compare value of 1 and with a higher value.
- Overflow marking while an earlier address is held.
- The write-one-to-clear behaviour of each status bit.

The bench's reference model is compared on every clock to back up these scenarios.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_CMP   = 3'd1,
        SEL_STAT  = 3'd2,
        SEL_SADDR = 3'd3,
        SEL_DADDR = 3'd4,
        SEL_COUNT = 3'd5
    } reg_sel_e;

    // bit 0 is the LSB (sbe_valid)
    typedef struct packed {
        logic sbe_irq;
        logic par;
        logic dbe_ovf;
        logic sbe_ovf;
        logic dbe_valid;
        logic sbe_valid;
    } status_t;

    localparam int STAT_BITS  = 6;
    localparam int NUM_CLASS  = 2;
    localparam int CLASS_SBE  = 0;
    localparam int CLASS_DBE  = 1;

    function automatic status_t w1c_mask(input logic [31:0] wdata);
        status_t m;
        m = status_t'(wdata[STAT_BITS-1:0]);
        return m;
    endfunction

endpackage

// File: rtl/ecc_beat_addr.sv
module ecc_beat_addr #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 4,
    parameter int BEAT_BYTES = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_BYTES);

    always_comb begin
        addr = base + (ADDR_W'(idx) * STEP);
    end
endmodule

// File: rtl/ecc_addr_capture.sv
module ecc_addr_capture #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              hit,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              valid_q,
    output logic              ovf_q,
    output logic [ADDR_W-1:0] addr_q
);
    logic valid_c;
    logic ovf_c;

    always_comb begin
        valid_c = valid_q & ~clr;
        ovf_c   = ovf_q & ~clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            ovf_q   <= 1'b0;
            addr_q  <= '0;
        end else begin
            valid_q <= valid_c | hit;
            ovf_q   <= ovf_c | (hit & valid_c);
            if (hit && !valid_c) begin
                addr_q <= addr_in;
            end
        end
    end
endmodule

// File: rtl/ecc_sbe_counter.sv
module ecc_sbe_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             hit,
    input  logic             match_mode,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count_q,
    output logic             irq_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_base;
    logic [CNT_W-1:0] cnt_next;
    logic             fire;

    always_comb begin
        cnt_base = clr ? '0 : count_q;
        if (!hit) begin
            cnt_next = cnt_base;
        end else if (cnt_base == CNT_MAX) begin
            cnt_next = CNT_MAX;
        end else begin
            cnt_next = cnt_base + 1'b1;
        end
        fire = hit & (~match_mode | (cnt_next == cmp));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            count_q <= cnt_next;
            irq_q   <= (irq_q & ~clr) | fire;
        end
    end
endmodule

// File: rtl/ecc_addr_logger.sv
module ecc_addr_logger
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 4,
    parameter int BEAT_BYTES = 8,
    parameter int CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_valid,
    input  logic [ADDR_W-1:0] beat_base_addr,
    input  logic [IDX_W-1:0]  beat_idx,
    input  logic              beat_sbe,
    input  logic              beat_dbe,
    input  logic              ext_parity_err,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_sbe,
    output logic              irq_dbe,
    output logic              irq_par
);
    reg_sel_e         sel;
    status_t          clr_m;
    status_t          status;
    logic             mode_q;
    logic [CNT_W-1:0] cmp_q;
    logic             par_q;
    logic             dbe_irq_q;
    logic [CNT_W-1:0] sbe_cnt;
    logic             sbe_irq;
    logic [ADDR_W-1:0] cur_addr;

    logic              cap_hit   [NUM_CLASS];
    logic              cap_clr   [NUM_CLASS];
    logic              cap_valid [NUM_CLASS];
    logic              cap_ovf   [NUM_CLASS];
    logic [ADDR_W-1:0] cap_addr  [NUM_CLASS];

    logic stat_wr;
    logic dbe_hit;
    logic sbe_hit;

    always_comb begin
        sel     = reg_sel_e'(reg_addr);
        stat_wr = reg_wr_en && (sel == SEL_STAT);
        clr_m   = stat_wr ? w1c_mask(reg_wdata) : '0;
        dbe_hit = beat_valid & beat_dbe;
        sbe_hit = beat_valid & beat_sbe & ~beat_dbe;
        cap_hit[CLASS_SBE] = sbe_hit;
        cap_hit[CLASS_DBE] = dbe_hit;
        cap_clr[CLASS_SBE] = clr_m.sbe_valid;
        cap_clr[CLASS_DBE] = clr_m.dbe_valid;
    end

    ecc_beat_addr #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BEAT_BYTES(BEAT_BYTES)
    ) u_addr (
        .base(beat_base_addr), .idx(beat_idx), .addr(cur_addr)
    );

    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_cap
        ecc_addr_capture #(.ADDR_W(ADDR_W)) u_cap (
            .clk     (clk),
            .rst     (rst),
            .clr     (cap_clr[g]),
            .hit     (cap_hit[g]),
            .addr_in (cur_addr),
            .valid_q (cap_valid[g]),
            .ovf_q   (cap_ovf[g]),
            .addr_q  (cap_addr[g])
        );
    end

    ecc_sbe_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr_m.sbe_irq),
        .hit        (sbe_hit),
        .match_mode (mode_q),
        .cmp        (cmp_q),
        .count_q    (sbe_cnt),
        .irq_q      (sbe_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= 1'b0;
            cmp_q     <= '0;
            par_q     <= 1'b0;
            dbe_irq_q <= 1'b0;
        end else begin
            if (reg_wr_en && sel == SEL_CTRL) mode_q <= reg_wdata[0];
            if (reg_wr_en && sel == SEL_CMP)  cmp_q  <= reg_wdata[CNT_W-1:0];
            par_q     <= (par_q & ~clr_m.par) | ext_parity_err;
            dbe_irq_q <= (dbe_irq_q & ~clr_m.dbe_valid) | dbe_hit;
        end
    end

    always_comb begin
        status.sbe_valid = cap_valid[CLASS_SBE];
        status.dbe_valid = cap_valid[CLASS_DBE];
        status.sbe_ovf   = cap_ovf[CLASS_SBE];
        status.dbe_ovf   = cap_ovf[CLASS_DBE];
        status.par       = par_q;
        status.sbe_irq   = sbe_irq;
        case (sel)
            SEL_CTRL:  reg_rdata = {31'd0, mode_q};
            SEL_CMP:   reg_rdata = 32'(cmp_q);
            SEL_STAT:  reg_rdata = 32'(status);
            SEL_SADDR: reg_rdata = 32'(cap_addr[CLASS_SBE]);
            SEL_DADDR: reg_rdata = 32'(cap_addr[CLASS_DBE]);
            SEL_COUNT: reg_rdata = 32'(sbe_cnt);
            default:   reg_rdata = 32'd0;
        endcase
        irq_sbe = sbe_irq;
        irq_dbe = dbe_irq_q;
        irq_par = par_q;
    end
endmodule

// File: rtl/ecc_addr_logger_chk.sv
module ecc_addr_logger_chk #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 4,
    parameter int BEAT_BYTES = 8,
    parameter int CNT_W      = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              beat_valid,
    input logic [ADDR_W-1:0] beat_base_addr,
    input logic [IDX_W-1:0]  beat_idx,
    input logic              beat_sbe,
    input logic              beat_dbe,
    input logic              ext_parity_err,
    input logic              reg_wr_en,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              irq_sbe,
    input logic              irq_dbe,
    input logic              irq_par,
    input logic              match_mode,
    input logic              sbe_valid,
    input logic [ADDR_W-1:0] sbe_addr,
    input logic [ADDR_W-1:0] dbe_addr,
    input logic [CNT_W-1:0]  sbe_count
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [ADDR_W-1:0] exp_addr;
    logic              sbe_ev;
    logic              dbe_ev;
    logic              cnt_clr;

    always_comb begin
        exp_addr = beat_base_addr + ADDR_W'(beat_idx) * ADDR_W'(BEAT_BYTES);
        sbe_ev   = beat_valid && beat_sbe && !beat_dbe;
        dbe_ev   = beat_valid && beat_dbe;
        cnt_clr  = reg_wr_en && reg_addr == 3'd2 && reg_wdata[5];
    end

    AST_SBE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (sbe_ev && !sbe_valid) |=> (sbe_valid && sbe_addr == $past(exp_addr))); // R1
    AST_DBE_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dbe_ev |=> $stable(dbe_addr)); // R5
    AST_PAR_IRQ: assert property (@(posedge clk) disable iff (rst)
        ext_parity_err |=> irq_par); // R5
    AST_DBE_IRQ: assert property (@(posedge clk) disable iff (rst)
        dbe_ev |=> irq_dbe); // R6
    AST_BOTH_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (dbe_ev && !cnt_clr) |=> $stable(sbe_count)); // R6
    AST_SBE_EVERY: assert property (@(posedge clk) disable iff (rst)
        (sbe_ev && !match_mode) |=> irq_sbe); // R3
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
        (sbe_count == CMAX && !cnt_clr) |=> sbe_count == CMAX); // R7
endmodule

bind ecc_addr_logger ecc_addr_logger_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BEAT_BYTES(BEAT_BYTES), .CNT_W(CNT_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .beat_valid     (beat_valid),
    .beat_base_addr (beat_base_addr),
    .beat_idx       (beat_idx),
    .beat_sbe       (beat_sbe),
    .beat_dbe       (beat_dbe),
    .ext_parity_err (ext_parity_err),
    .reg_wr_en      (reg_wr_en),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .irq_sbe        (irq_sbe),
    .irq_dbe        (irq_dbe),
    .irq_par        (irq_par),
    .match_mode     (mode_q),
    .sbe_valid      (cap_valid[0]),
    .sbe_addr       (cap_addr[0]),
    .dbe_addr       (cap_addr[1]),
    .sbe_count      (sbe_cnt)
);

// File: tb/ecc_addr_logger_tb.sv
module ecc_addr_logger_tb;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 4;
    localparam int BB     = 8;
    localparam int CNT_W  = 8;
    localparam int CMAX   = 255;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              beat_valid = 1'b0;
    logic [ADDR_W-1:0] beat_base_addr = '0;
    logic [IDX_W-1:0]  beat_idx = '0;
    logic              beat_sbe = 1'b0;
    logic              beat_dbe = 1'b0;
    logic              ext_parity_err = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [2:0]        reg_addr = 3'd0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq_sbe, irq_dbe, irq_par;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ecc_addr_logger #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BEAT_BYTES(BB), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .beat_valid(beat_valid), .beat_base_addr(beat_base_addr),
        .beat_idx(beat_idx), .beat_sbe(beat_sbe), .beat_dbe(beat_dbe),
        .ext_parity_err(ext_parity_err), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_sbe(irq_sbe),
        .irq_dbe(irq_dbe), .irq_par(irq_par));

    // behavioural reference model
    int m_mode, m_cmp, m_cnt;
    bit m_sv, m_dv, m_so, m_do, m_par, m_isbe, m_idbe;
    longint m_saddr, m_daddr;

    function automatic logic [31:0] m_rd(input logic [2:0] a);
        case (a)
            3'd0: return 32'(m_mode);
            3'd1: return 32'(m_cmp);
            3'd2: return {26'd0, m_isbe, m_par, m_do, m_so, m_dv, m_sv};
            3'd3: return 32'(m_saddr);
            3'd4: return 32'(m_daddr);
            3'd5: return 32'(m_cnt);
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_cmp = 0; m_cnt = 0; m_sv = 0; m_dv = 0; m_so = 0; m_do = 0;
            m_par = 0; m_isbe = 0; m_idbe = 0; m_saddr = 0; m_daddr = 0;
        end else begin
            int old_mode, old_cmp;
            longint a;
            old_mode = m_mode; old_cmp = m_cmp;
            a = (longint'(beat_base_addr) + longint'(beat_idx) * BB) % (64'd1 << ADDR_W);
            if (reg_wr_en && reg_addr == 3'd0) m_mode = int'(reg_wdata[0]);
            if (reg_wr_en && reg_addr == 3'd1) m_cmp = int'(reg_wdata[CNT_W-1:0]);
            if (reg_wr_en && reg_addr == 3'd2) begin
                if (reg_wdata[0]) begin m_sv = 0; m_so = 0; end
                if (reg_wdata[1]) begin m_dv = 0; m_do = 0; m_idbe = 0; end
                if (reg_wdata[4]) m_par = 0;
                if (reg_wdata[5]) begin m_cnt = 0; m_isbe = 0; end
            end
            if (ext_parity_err) m_par = 1;
            if (beat_valid && beat_dbe) begin
                if (m_dv) m_do = 1; else begin m_dv = 1; m_daddr = a; end
                m_idbe = 1;
            end else if (beat_valid && beat_sbe) begin
                if (m_sv) m_so = 1; else begin m_sv = 1; m_saddr = a; end
                if (m_cnt < CMAX) m_cnt++;
                if (old_mode == 0 || m_cnt == old_cmp) m_isbe = 1;
            end
        end
    end

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            checks++;
            if (irq_sbe !== m_isbe || irq_dbe !== m_idbe || irq_par !== m_par ||
                reg_rdata !== m_rd(reg_addr)) begin
                errors++;
                $display("FAIL R8 model cycle: irq %b%b%b rdata %h expected irq %b%b%b rdata %h",
                    irq_sbe, irq_dbe, irq_par, reg_rdata, m_isbe, m_idbe, m_par, m_rd(reg_addr));
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0; reg_wdata = '0;
    endtask

    task automatic beat(input logic [31:0] base, input int idx, input bit s, input bit d);
        @(negedge clk);
        beat_valid = 1; beat_base_addr = base; beat_idx = IDX_W'(idx); beat_sbe = s; beat_dbe = d;
        @(negedge clk);
        beat_valid = 0; beat_sbe = 0; beat_dbe = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL R8 watchdog expired actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R8 reset state
        rd_chk("R8 reset status", 3'd2, 32'd0);
        rd_chk("R8 reset count", 3'd5, 32'd0);
        check("R8 reset irqs", {29'd0, irq_sbe, irq_dbe, irq_par}, 32'd0);

        // R1 odd beat, R3 mode 0 irq
        beat(32'h1000, 3, 1, 0);
        rd_chk("R1 odd-beat sbe address", 3'd3, 32'h1018);
        check("R3 irq_sbe on every error", 32'(irq_sbe), 32'd1);
        // R2 second error holds address, sets overflow
        beat(32'h1000, 4, 1, 0);
        rd_chk("R2 sbe address held", 3'd3, 32'h1018);
        rd_chk("R2 status sbe valid+ovf", 3'd2, 32'h25);
        // R6 dbe, R1 odd beat
        beat(32'h2000, 5, 0, 1);
        rd_chk("R1 odd-beat dbe address", 3'd4, 32'h2028);
        check("R6 irq_dbe", 32'(irq_dbe), 32'd1);
        // R5 parity leaves dbe log alone
        @(negedge clk); ext_parity_err = 1;
        @(negedge clk); ext_parity_err = 0;
        rd_chk("R5 dbe address unchanged by parity", 3'd4, 32'h2028);
        rd_chk("R5 parity status bit", 3'd2, 32'h37);
        check("R5 irq_par", 32'(irq_par), 32'd1);
        // R8 W1C clears everything
        wr(3'd2, 32'h3F);
        rd_chk("R8 status after clear", 3'd2, 32'd0);
        rd_chk("R8 count after clear", 3'd5, 32'd0);
        check("R8 irqs after clear", {29'd0, irq_sbe, irq_dbe, irq_par}, 32'd0);
        // R6 both flags -> dbe only, even beat
        beat(32'h3000, 2, 1, 1);
        rd_chk("R6 both flags count unchanged", 3'd5, 32'd0);
        rd_chk("R6 both flags dbe address", 3'd4, 32'h3010);
        rd_chk("R6 both flags status", 3'd2, 32'h02);
        check("R6 both flags no irq_sbe", 32'(irq_sbe), 32'd0);
        wr(3'd2, 32'h3F);
        // R4 match mode, compare 1
        wr(3'd0, 32'd1);
        wr(3'd1, 32'd1);
        beat(32'h4000, 7, 1, 0);
        check("R4 compare 1 fires", 32'(irq_sbe), 32'd1);
        rd_chk("R4 compare 1 captures beat address", 3'd3, 32'h4038);
        // R4 compare 3
        wr(3'd2, 32'h3F);
        wr(3'd1, 32'd3);
        beat(32'h5000, 0, 1, 0);
        beat(32'h5000, 1, 1, 0);
        check("R4 no irq before match", 32'(irq_sbe), 32'd0);
        beat(32'h5000, 2, 1, 0);
        check("R4 irq at match", 32'(irq_sbe), 32'd1);
        rd_chk("R4 address of first error", 3'd3, 32'h5000);
        // R6 dbe irq in match mode
        beat(32'h6000, 1, 0, 1);
        check("R6 irq_dbe in match mode", 32'(irq_dbe), 32'd1);
        // R7 saturation
        wr(3'd2, 32'h3F);
        wr(3'd0, 32'd0);
        for (int i = 0; i < 300; i++) beat(32'h7000, i % 16, 1, 0);
        rd_chk("R7 count saturates", 3'd5, 32'(CMAX));
        wr(3'd2, 32'h20);
        rd_chk("R8 bit5 clears count", 3'd5, 32'd0);
        rd_chk("R8 bit5 keeps sbe valid", 3'd2, 32'h05);

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule